// File: doc/BRIEF.md
# Serial Byte to Block Cipher Streaming Controller

This controller connects a byte-wide serial receiver and transmitter to a 128-bit block cipher engine. Bytes from the receiver are packed into a 128-bit block. When the sixteenth byte of a block has been stored, the block and a constant key go to the cipher engine. The controller then waits for the engine to finish.

The engine's 128-bit answer is captured. It is then sent back out one byte at a time through a 16-way byte selector. Each byte uses a valid/ready handshake with the transmitter. A block counter tracks how many blocks of the frame are done. A frame is 4096 bytes, which is 256 blocks. After the last byte of the final block has been sent, a one-cycle completion pulse marks the end of the frame. The counters are then cleared for the next frame.

While the controller is busy with the engine or with sending, it does not accept input. Its receive ready stays low, so the upstream source must hold its byte, and no byte is lost.

Top module: `cipher_stream_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves rxReady, txValid, cipherStart and frameDone low and drives cipherIn to zero.
- R2: Bytes are packed most-significant first: the first accepted byte of a block appears on cipherIn[127:120] and the sixteenth on cipherIn[7:0]; cipherStart is high in the cycle right after the sixteenth byte is accepted.
- R3: From acceptance of a block's sixteenth byte until its last result byte is accepted, rxReady stays low, so an offered byte is held off and later accepted unchanged, never dropped.
- R4: cipherKey equals the KEY parameter, and cipherIn and cipherKey stay stable from cipherStart until cipherDone.
- R5: The 128-bit cipherOut present in the cipherDone cycle is captured and sent as 16 bytes, with bits 127:120 first and bits 7:0 last; cipherOut in other cycles has no effect.
- R6: A result byte is shown with txValid and held with txData stable until txReady; in the cycle after each accepted byte txValid is low, and only then does the selector move to the next byte.
- R7: After the last result byte of a block that is not the last of its frame, rxReady is high in the following cycle.
- R8: After the last result byte of block 256 of a frame, frameDone is high for exactly one cycle. rxReady stays low for that cycle and for one further cycle. The block count then restarts from zero, and frameDone does not pulse at any other time.
- R9: cipherStart is high for exactly one cycle per block and is never raised while a result is still awaited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxData | input | 8 | Byte from the serial receiver |
| rxValid | input | 1 | rxData holds a byte |
| rxReady | output | 1 | Controller accepts a byte this cycle |
| txData | output | 8 | Result byte to the serial transmitter |
| txValid | output | 1 | txData holds a byte to send |
| txReady | input | 1 | Transmitter takes the byte this cycle |
| cipherStart | output | 1 | One-cycle start request to the engine |
| cipherKey | output | 128 | Constant key |
| cipherIn | output | 128 | Block to process |
| cipherDone | input | 1 | One-cycle completion from the engine |
| cipherOut | input | 128 | Engine result, valid with cipherDone |
| frameDone | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench streams one full frame of 256 blocks and then two blocks of the next frame. The block contents rotate among four patterns: a count, all ones, alternating 0xA5/0x5A, and a mixed arithmetic byte. These patterns show whether the packing order and the byte selector order are wrong, because a swapped or shifted byte changes the result.

Input gaps, upstream bytes held through busy periods, and periodic transmitter stalls each show something different. The gaps separate real handshakes from counting by cycles. The held bytes show that data is held off rather than lost. The stalls show that the selector moves only on an accepted byte.

The engine model answers after a latency of one to four cycles and puts junk on cipherOut outside the done cycle. This shows whether the result is captured at the right moment.

// File: rtl/cipher_stream_pkg.sv
package cipher_stream_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_COLLECT, S_START, S_WAIT, S_SEND, S_GAP, S_DONE
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic captureOut;
    logic advanceTx;
    logic endBlock;
    logic clearFrame;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic lastByte;
    logic lastTx;
    logic lastBlock;
  } dpStat_t;

endpackage

// File: rtl/cipher_stream_dp.sv
module cipher_stream_dp
  import cipher_stream_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int BLOCK_W = 128,
  parameter int BLOCKS  = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  dpCtrl_t            ctl,
  input  logic [BYTE_W-1:0]  rxData,
  input  logic [BLOCK_W-1:0] cipherOut,
  output logic [BLOCK_W-1:0] blockBuf,
  output logic [BYTE_W-1:0]  txByte,
  output dpStat_t            stat
);
  localparam int NBYTES = BLOCK_W / BYTE_W;
  localparam int IDX_W  = $clog2(NBYTES);
  localparam int BLK_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;

  logic [BLOCK_W-1:0] collectReg;
  logic [BLOCK_W-1:0] resultReg;
  logic [IDX_W-1:0]   byteCnt;
  logic [IDX_W-1:0]   txIdx;
  logic [BLK_W-1:0]   blockCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      collectReg <= '0;
      resultReg  <= '0;
      byteCnt    <= '0;
      txIdx      <= '0;
      blockCnt   <= '0;
    end else begin
      if (ctl.shiftIn) begin
        // shifting in at the low end leaves the first byte on top
        collectReg <= {collectReg[BLOCK_W-BYTE_W-1:0], rxData};
        byteCnt    <= stat.lastByte ? '0 : byteCnt + 1'b1;
      end
      if (ctl.captureOut) resultReg <= cipherOut;
      if (ctl.advanceTx)  txIdx <= stat.lastTx ? '0 : txIdx + 1'b1;
      if (ctl.clearFrame)    blockCnt <= '0;
      else if (ctl.endBlock) blockCnt <= blockCnt + 1'b1;
    end
  end

  // byte selector: entry 0 is the most significant byte
  logic [BYTE_W-1:0] resBytes [NBYTES];
  for (genvar g = 0; g < NBYTES; g++) begin : g_sel
    assign resBytes[g] = resultReg[BLOCK_W-1-g*BYTE_W -: BYTE_W];
  end

  assign txByte         = resBytes[txIdx];
  assign blockBuf       = collectReg;
  assign stat.lastByte  = (byteCnt == IDX_W'(NBYTES - 1));
  assign stat.lastTx    = (txIdx == IDX_W'(NBYTES - 1));
  assign stat.lastBlock = (blockCnt == BLK_W'(BLOCKS - 1));
endmodule

// File: rtl/cipher_stream_fsm.sv
module cipher_stream_fsm
  import cipher_stream_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rxValid,
  input  logic    txReady,
  input  logic    cipherDone,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    rxReady,
  output logic    txValid,
  output logic    cipherStart,
  output logic    frameDone
);
  ctrlState_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      S_IDLE:    nextState = S_COLLECT;
      S_COLLECT: if (rxValid) begin
        ctl.shiftIn = 1'b1;
        if (stat.lastByte) nextState = S_START;
      end
      S_START:   nextState = S_WAIT;
      S_WAIT:    if (cipherDone) begin
        ctl.captureOut = 1'b1;
        nextState      = S_SEND;
      end
      S_SEND:    if (txReady) begin
        ctl.advanceTx = 1'b1;
        if (stat.lastTx) begin
          ctl.endBlock   = 1'b1;
          ctl.clearFrame = stat.lastBlock;
          nextState      = stat.lastBlock ? S_DONE : S_COLLECT;
        end else begin
          nextState = S_GAP;
        end
      end
      S_GAP:     nextState = S_SEND;
      S_DONE:    nextState = S_IDLE;
      default:   nextState = S_IDLE;
    endcase
  end

  assign rxReady     = (state == S_COLLECT);
  assign txValid     = (state == S_SEND);
  assign cipherStart = (state == S_START);
  assign frameDone   = (state == S_DONE);
endmodule

// File: rtl/cipher_stream_ctrl.sv
module cipher_stream_ctrl
  import cipher_stream_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int BLOCK_W = 128,
  parameter int BLOCKS  = 256,
  parameter logic [BLOCK_W-1:0] KEY = 128'h2b7e_1516_28ae_d2a6_abf7_1588_09cf_4f3c
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BYTE_W-1:0]  rxData,
  input  logic               rxValid,
  output logic               rxReady,
  output logic [BYTE_W-1:0]  txData,
  output logic               txValid,
  input  logic               txReady,
  output logic               cipherStart,
  output logic [BLOCK_W-1:0] cipherKey,
  output logic [BLOCK_W-1:0] cipherIn,
  input  logic               cipherDone,
  input  logic [BLOCK_W-1:0] cipherOut,
  output logic               frameDone
);
  dpCtrl_t ctl;
  dpStat_t stat;

  cipher_stream_fsm i_fsm (
    .clk(clk), .rst(rst), .rxValid(rxValid), .txReady(txReady),
    .cipherDone(cipherDone), .stat(stat), .ctl(ctl), .rxReady(rxReady),
    .txValid(txValid), .cipherStart(cipherStart), .frameDone(frameDone)
  );

  cipher_stream_dp #(.BYTE_W(BYTE_W), .BLOCK_W(BLOCK_W), .BLOCKS(BLOCKS)) i_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .rxData(rxData), .cipherOut(cipherOut),
    .blockBuf(cipherIn), .txByte(txData), .stat(stat)
  );

  assign cipherKey = KEY;
endmodule

// File: rtl/cipher_stream_chk.sv
module cipher_stream_chk #(
  parameter int BLOCK_W = 128
) (
  input logic               clk,
  input logic               rst,
  input logic               rxReady,
  input logic               txValid,
  input logic               txReady,
  input logic [7:0]         txData,
  input logic               cipherStart,
  input logic               cipherDone,
  input logic [BLOCK_W-1:0] cipherIn,
  input logic [BLOCK_W-1:0] cipherKey,
  input logic               frameDone
);
  logic awaiting;
  always_ff @(posedge clk) begin
    if (rst)             awaiting <= 1'b0;
    else if (cipherStart) awaiting <= 1'b1;
    else if (cipherDone)  awaiting <= 1'b0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rxReady && !txValid && !cipherStart && !frameDone));

  // R3
  rx_holdoff_chk: assert property (@(posedge clk) disable iff (rst)
    (txValid || awaiting || cipherStart) |-> !rxReady);

  // R4
  cipher_hold_chk: assert property (@(posedge clk) disable iff (rst)
    awaiting |-> ($stable(cipherIn) && $stable(cipherKey)));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  // R6
  tx_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (txValid && txReady) |=> !txValid);

  // R8
  frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> (!frameDone && !rxReady));

  // R9
  single_start_chk: assert property (@(posedge clk) disable iff (rst)
    cipherStart |=> !cipherStart);

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    awaiting |-> !cipherStart);
endmodule

bind cipher_stream_ctrl cipher_stream_chk #(.BLOCK_W(BLOCK_W)) i_chk (
  .clk(clk), .rst(rst), .rxReady(rxReady), .txValid(txValid),
  .txReady(txReady), .txData(txData), .cipherStart(cipherStart),
  .cipherDone(cipherDone), .cipherIn(cipherIn), .cipherKey(cipherKey),
  .frameDone(frameDone)
);

// File: tb/test_cipher_stream_ctrl.sv
module test_cipher_stream_ctrl;
  localparam logic [127:0] K = 128'h0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0;
  localparam int NBLK = 256;
  localparam int TOTAL = NBLK + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rxData = '0;
  logic rxValid = 1'b0, txReady = 1'b0, cipherDone = 1'b0;
  logic [127:0] cipherOut = '0;
  logic rxReady, txValid, cipherStart, frameDone;
  logic [7:0] txData;
  logic [127:0] cipherKey, cipherIn;

  cipher_stream_ctrl #(.BLOCKS(NBLK), .KEY(K)) i_cipher_stream_ctrl (
    .clk(clk), .rst(rst), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .cipherStart(cipherStart), .cipherKey(cipherKey), .cipherIn(cipherIn),
    .cipherDone(cipherDone), .cipherOut(cipherOut), .frameDone(frameDone)
  );

  always #2 clk = ~clk;

  int nCmp = 0, nBad = 0;
  logic [7:0] expQ[$];
  int sentBlocks = 0, frameCnt = 0;
  bit wdFired = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] engine(input logic [127:0] x);
    return {x[119:0], x[127:120]} ^ K ^ 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  endfunction

  function automatic logic [7:0] patByte(input int b, input int i);
    case (b % 4)
      0: return 8'(b + i);
      1: return 8'hFF;
      2: return (i % 2 == 1) ? 8'hA5 : 8'h5A;
      default: return 8'(i * 17 + b * 3 + 1);
    endcase
  endfunction

  // driver: feeds blocks, pushes expected result bytes
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rxReady && !txValid && !cipherStart && !frameDone, "R1 outputs",
        {rxReady, txValid, cipherStart, frameDone}, 0);
    chk(cipherIn == '0, "R1 buffer", cipherIn, 0);
    rst = 1'b0;
    for (int b = 0; b < TOTAL; b++) begin
      logic [127:0] blk;
      for (int i = 0; i < 16; i++) blk[127-8*i -: 8] = patByte(b, i);
      for (int i = 0; i < 16; i++) begin
        bit took;
        if (b % 3 == 1 && i % 5 == 2) begin
          rxValid = 1'b0;
          @(negedge clk);
        end
        rxValid = 1'b1;
        rxData  = blk[127-8*i -: 8];
        do begin
          took = rxReady;
          @(negedge clk);
        end while (!took);
      end
      for (int i = 0; i < 16; i++) expQ.push_back(engine(blk)[127-8*i -: 8]);
      if (b + 1 < TOTAL) rxData = patByte(b + 1, 0);
      else rxValid = 1'b0;
      // R2: start follows the 16th byte, packing is most significant first
      chk(cipherStart, "R2 start timing", cipherStart, 1);
      chk(cipherIn == blk, "R2 packing", cipherIn, blk);
      // R3: held off while busy
      chk(!rxReady, "R3 holdoff", rxReady, 0);
    end
    rxValid = 1'b0;
  end

  // cipher engine model
  bit mBusy = 0;
  int mCnt = 0, mStarts = 0;
  logic [127:0] mHeld;
  always @(negedge clk) begin
    if (!rst) begin
      if (mBusy) begin
        chk(cipherIn == mHeld, "R4 input stable", cipherIn, mHeld);
        chk(!rxReady && !txValid, "R3 idle while waiting", {rxReady, txValid}, 0);
        if (cipherStart) chk(0, "R9 restart", 1, 0);
        if (mCnt == 0) begin
          cipherDone = 1'b1;
          cipherOut  = engine(mHeld);
          mBusy      = 0;
        end else mCnt--;
      end else begin
        cipherDone = 1'b0;
        cipherOut  = {4{32'hDEAD_BEEF}} ^ {32{mCnt[3:0]}};
        if (cipherStart) begin
          chk(cipherKey == K, "R4 key", cipherKey, K);
          mHeld = cipherIn;
          mBusy = 1;
          mCnt  = mStarts % 4;
          mStarts++;
        end
      end
    end
  end

  // monitor: transmitter side, scoreboard pops
  int mCycle = 0, txIdx = 0, post = 0;
  bit gapDue = 0, holdPrev = 0;
  logic [7:0] prevData;
  always @(negedge clk) begin
    mCycle++;
    txReady = (sentBlocks % 2 == 1) ? (mCycle % 4 != 1) : 1'b1;
    if (frameDone) frameCnt++;
    if (!rst) begin
      if (gapDue) begin
        chk(!txValid, "R6 gap", txValid, 0);
        gapDue = 0;
      end
      case (post)
        1: begin chk(rxReady && !frameDone, "R7 resume", {rxReady, frameDone}, 2'b10); post = 0; end
        2: begin chk(frameDone && !rxReady, "R8 pulse", {frameDone, rxReady}, 2'b10); post = 3; end
        3: begin chk(!frameDone && !rxReady, "R8 one cycle", {frameDone, rxReady}, 0); post = 4; end
        4: begin chk(rxReady, "R8 restart", rxReady, 1); post = 0; end
        default: ;
      endcase
      if (txValid) begin
        chk(!rxReady, "R3 busy send", rxReady, 0);
        if (holdPrev) chk(txData == prevData, "R6 hold", txData, prevData);
        if (txReady) begin
          holdPrev = 0;
          gapDue   = 1;
          if (expQ.size() == 0) chk(0, "R5 unexpected byte", txData, 0);
          else begin
            logic [7:0] e;
            e = expQ.pop_front();
            chk(txData == e, "R5 byte order", txData, e);
          end
          if (txIdx == 15) begin
            txIdx = 0;
            sentBlocks++;
            post = (sentBlocks == NBLK) ? 2 : 1;
            gapDue = 0;
          end else txIdx++;
        end else begin
          holdPrev = 1;
          prevData = txData;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    wdFired = 1;
  end

  initial begin
    wait (sentBlocks == TOTAL || wdFired);
    repeat (5) @(negedge clk);
    chk(!wdFired, "watchdog", sentBlocks, TOTAL);
    chk(frameCnt == 1, "R8 pulse count", frameCnt, 1);
    chk(expQ.size() == 0, "R5 leftover", expQ.size(), 0);
    chk(mStarts == TOTAL, "R9 start count", mStarts, TOTAL);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule